// File: doc/BRIEF.md
# Per-Core Interrupt CPU Interface

This block sits between an interrupt distributor and a single processor core. Each cycle the distributor offers one candidate: an interrupt ID and its 8-bit priority, where smaller numbers are more urgent. The interface raises the core's interrupt line when that candidate is more urgent than both a programmable priority threshold and the priority of whatever the core is already servicing.

Software works through a small register port. The port has separate read and write channels, so one read and one write can happen in the same cycle. A read of the acknowledge register claims the candidate. The read returns the candidate's ID, pulses an activation strobe back to the distributor, and makes that priority the new running priority. Completion is signalled by writing the same ID to the completion register. This pops the newest active entry, restores the priority that was running before it, and pulses a completion strobe to the distributor. Active interrupts can nest up to a fixed depth.

Top module: `irq_core_iface`

## Requirements
- R1: Register offsets are 0 = control (bit 0 enable), 1 = priority threshold (bits 7:0), 2 = acknowledge (read) and 3 = completion (write) / running priority (read). After reset the interrupt line is low. Control reads 0, the threshold reads 0x00 and the running priority reads 0xFF.
- R2: The interrupt line is high in the same cycle exactly when all of these hold: the interface is enabled, a candidate is offered with an ID below 1020, its priority is strictly below both the threshold and the running priority, and fewer than 4 interrupts are active.
- R3: While control bit 0 is clear the interrupt line stays low and acknowledge reads return 1023.
- R4: An acknowledge read with an eligible candidate returns the candidate ID in bits 9:0 with zeros above. It pulses the activation strobe with that ID, and from the next cycle the running priority equals the candidate's priority.
- R5: An acknowledge read with no eligible candidate returns 1023, gives no activation strobe and leaves the running priority unchanged.
- R6: The threshold comparison is strict: a candidate whose priority equals the threshold is not forwarded. With a threshold of 0xF0, priority 0xEF is forwarded and 0xF0 is not.
- R7: A completion write whose bits 9:0 equal the ID of the newest active entry pulses the completion strobe with that ID. It restores the running priority to that of the entry below it, or to 0xFF when none remains.
- R8: A completion write whose ID differs from the newest active entry, or that arrives with nothing active, is ignored: no strobe and no change of running priority.
- R9: At most 4 interrupts are active at once. With 4 active, an acknowledge read returns 1023 and the line is low.
- R10: Candidate IDs 1020 to 1023 are never forwarded or acknowledged.
- R11: When an acknowledge read and a completion write fall in the same cycle, both are judged on the state before that cycle. Eligibility uses the old running priority and the old active count. The completion is applied first and the acknowledge then pushes its entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe (acknowledge has side effects) |
| reg_rd_addr | input | 2 | Register read offset |
| reg_rd_data | output | 32 | Read data in the same cycle as the strobe; zero when not reading |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| act_valid | output | 1 | Candidate was claimed this cycle |
| act_id | output | 10 | ID being made active |
| done_valid | output | 1 | An active interrupt completed this cycle |
| done_id | output | 10 | ID being completed |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The acknowledge read and the completion write can land in the same cycle on their separate channels. The bench provokes this in two ways: with a candidate more urgent than the current running priority, and with the active stack already full. A completion that pops the top while a new ID is claimed must leave the stack depth unchanged, with the new priority running. When the stack was full at the start of the cycle, the claim must fail with 1023 while the pop still happens. A behavioural queue model judges every cycle, and a long run of mixed random traffic keeps reads and writes colliding.

// File: rtl/irq_iface_pkg.sv
package irq_iface_pkg;

   localparam int unsigned DEF_ID_W   = 10;
   localparam int unsigned DEF_PRIO_W = 8;
   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_NEST   = 4;

   typedef enum logic [1:0] {
      OFS_CTRL = 2'd0,
      OFS_MASK = 2'd1,
      OFS_ACK  = 2'd2,
      OFS_DONE = 2'd3
   } reg_ofs_e;

endpackage

// File: rtl/irq_active_stack.sv
// Stack of active interrupts (ID + priority). Push and pop may coincide:
// the pop removes the top and the push takes its slot.
module irq_active_stack #(
   parameter int unsigned ID_W   = 10,
   parameter int unsigned PRIO_W = 8,
   parameter int unsigned NEST   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [ID_W-1:0]   push_id,
   input  logic [PRIO_W-1:0] push_prio,
   output logic [ID_W-1:0]   top_id,
   output logic [PRIO_W-1:0] top_prio,
   output logic              empty,
   output logic              full
);
   localparam int unsigned     CNT_W    = $clog2(NEST + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NEST);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
   localparam logic [PRIO_W-1:0] IDLE    = '1;

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  slot;
   logic [ID_W-1:0]   id_q [NEST];
   logic [PRIO_W-1:0] pr_q [NEST];

   generate
      if (NEST < 2) begin : g_bad_nest
         $error("irq_active_stack: NEST must be at least 2");
      end
   endgenerate

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == FULL_CNT);
   assign slot  = pop ? (cnt_q - ONE) : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + ONE;
            2'b01:   cnt_q <= cnt_q - ONE;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NEST; i++) begin
            id_q[i] <= '0;
            pr_q[i] <= IDLE;
         end
      end else if (push) begin
         for (int i = 0; i < NEST; i++) begin
            if (slot == CNT_W'(i)) begin
               id_q[i] <= push_id;
               pr_q[i] <= push_prio;
            end
         end
      end
   end

   always_comb begin
      top_id   = '0;
      top_prio = IDLE;
      for (int i = 0; i < NEST; i++) begin
         if (cnt_q == CNT_W'(i + 1)) begin
            top_id   = id_q[i];
            top_prio = pr_q[i];
         end
      end
   end

endmodule

// File: rtl/irq_gate.sv
// Decides whether the offered candidate may be signalled and claimed.
module irq_gate #(
   parameter int unsigned ID_W   = 10,
   parameter int unsigned PRIO_W = 8
) (
   input  logic              enable,
   input  logic [PRIO_W-1:0] mask,
   input  logic [PRIO_W-1:0] run_prio,
   input  logic              nest_full,
   input  logic              cand_valid,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [PRIO_W-1:0] cand_prio,
   output logic              fwd_ok
);
   localparam logic [ID_W-1:0] RESV_ID = ID_W'((2 ** ID_W) - 4);

   logic id_ok, beats_mask, beats_run;

   assign id_ok      = (cand_id < RESV_ID);
   assign beats_mask = (cand_prio < mask);
   assign beats_run  = (cand_prio < run_prio);
   assign fwd_ok     = enable && cand_valid && id_ok && beats_mask
                       && beats_run && !nest_full;

endmodule

// File: rtl/irq_regs.sv
// Control and threshold registers plus the read multiplexer.
module irq_regs
   import irq_iface_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ID_W   = 10,
   parameter int unsigned PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [PRIO_W-1:0] wr_low,
   input  logic              rd_en,
   input  logic [1:0]        rd_addr,
   input  logic [ID_W-1:0]   ack_id,
   input  logic [PRIO_W-1:0] run_prio,
   output logic              enable,
   output logic [PRIO_W-1:0] mask,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         mask   <= '0;
      end else if (wr_en) begin
         if (wr_addr == OFS_CTRL) enable <= wr_low[0];
         if (wr_addr == OFS_MASK) mask   <= wr_low;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (rd_addr)
            OFS_CTRL: rd_data = DATA_W'(enable);
            OFS_MASK: rd_data = DATA_W'(mask);
            OFS_ACK:  rd_data = DATA_W'(ack_id);
            default:  rd_data = DATA_W'(run_prio);
         endcase
      end
   end

endmodule

// File: rtl/irq_core_iface.sv
module irq_core_iface
   import irq_iface_pkg::*;
#(
   parameter int unsigned ID_W    = DEF_ID_W,
   parameter int unsigned PRIO_W  = DEF_PRIO_W,
   parameter int unsigned DATA_W  = DEF_DATA_W,
   parameter int unsigned NEST    = DEF_NEST,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_addr,
   input  logic [DATA_W-1:0] reg_wr_data,
   input  logic              reg_rd_en,
   input  logic [1:0]        reg_rd_addr,
   output logic [DATA_W-1:0] reg_rd_data,
   input  logic              cand_valid,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [PRIO_W-1:0] cand_prio,
   output logic              act_valid,
   output logic [ID_W-1:0]   act_id,
   output logic              done_valid,
   output logic [ID_W-1:0]   done_id,
   output logic              irq_o
);
   localparam logic [ID_W-1:0] SPUR_ID = '1;

   generate
      if (DATA_W < ID_W) begin : g_bad_data
         $error("irq_core_iface: DATA_W must hold an ID");
      end
      if (PRIO_W > ID_W) begin : g_bad_prio
         $error("irq_core_iface: PRIO_W must not exceed ID_W");
      end
      if (ID_W < 6) begin : g_bad_id
         $error("irq_core_iface: ID_W too small");
      end
   endgenerate

   logic              enable;
   logic [PRIO_W-1:0] mask;
   logic [PRIO_W-1:0] run_prio;
   logic [ID_W-1:0]   top_id;
   logic              empty, full;
   logic              fwd_ok;
   logic              do_push, do_pop;
   logic [ID_W-1:0]   ack_id;
   logic              unused_wr_hi;

   assign unused_wr_hi = ^reg_wr_data[DATA_W-1:ID_W];

   irq_regs #(.DATA_W(DATA_W), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_addr  (reg_wr_addr),
      .wr_low   (reg_wr_data[PRIO_W-1:0]),
      .rd_en    (reg_rd_en),
      .rd_addr  (reg_rd_addr),
      .ack_id   (ack_id),
      .run_prio (run_prio),
      .enable   (enable),
      .mask     (mask),
      .rd_data  (reg_rd_data)
   );

   irq_gate #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_gate (
      .enable     (enable),
      .mask       (mask),
      .run_prio   (run_prio),
      .nest_full  (full),
      .cand_valid (cand_valid),
      .cand_id    (cand_id),
      .cand_prio  (cand_prio),
      .fwd_ok     (fwd_ok)
   );

   assign ack_id  = fwd_ok ? cand_id : SPUR_ID;
   assign do_push = reg_rd_en && (reg_rd_addr == OFS_ACK) && fwd_ok;
   assign do_pop  = reg_wr_en && (reg_wr_addr == OFS_DONE) && !empty
                    && (reg_wr_data[ID_W-1:0] == top_id);

   irq_active_stack #(.ID_W(ID_W), .PRIO_W(PRIO_W), .NEST(NEST)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (do_push),
      .pop       (do_pop),
      .push_id   (cand_id),
      .push_prio (cand_prio),
      .top_id    (top_id),
      .top_prio  (run_prio),
      .empty     (empty),
      .full      (full)
   );

   assign act_valid  = do_push;
   assign act_id     = cand_id;
   assign done_valid = do_pop;
   assign done_id    = top_id;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= fwd_ok;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = fwd_ok;
      end
   endgenerate

endmodule

// File: rtl/irq_core_iface_chk.sv
module irq_core_iface_chk #(
   parameter int unsigned ID_W    = 10,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NEST    = 4,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [1:0]        reg_wr_addr,
   input logic [DATA_W-1:0] reg_wr_data,
   input logic              reg_rd_en,
   input logic [1:0]        reg_rd_addr,
   input logic [DATA_W-1:0] reg_rd_data,
   input logic              act_valid,
   input logic [ID_W-1:0]   act_id,
   input logic              done_valid,
   input logic [ID_W-1:0]   done_id,
   input logic              irq_o
);
   localparam logic [ID_W-1:0] SPUR_ID = '1;
   localparam logic [ID_W-1:0] RESV_ID = ID_W'((2 ** ID_W) - 4);
   localparam logic [7:0]      NEST_C  = 8'(NEST);

   logic [7:0] live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= '0;
      else if (act_valid && !done_valid) live_q <= live_q + 8'd1;
      else if (done_valid && !act_valid) live_q <= live_q - 8'd1;
   end

   AST_ACT_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (reg_rd_en && reg_rd_addr == 2'd2 && reg_rd_data[ID_W-1:0] == act_id)); // R4
   AST_ACT_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (act_id < RESV_ID)); // R10
   AST_SPURIOUS_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && reg_rd_addr == 2'd2 && reg_rd_data[ID_W-1:0] == SPUR_ID) |-> !act_valid); // R5
   AST_DONE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (reg_wr_en && reg_wr_addr == 2'd3 && reg_wr_data[ID_W-1:0] == done_id)); // R7
   AST_DONE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (live_q != 8'd0)); // R8
   AST_NEST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && !done_valid) |-> (live_q < NEST_C)); // R9
   AST_CLAIM_SIGNALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && act_valid) |-> irq_o); // R2
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && reg_wr_en && reg_wr_addr == 2'd0 && !reg_wr_data[0]) |=> !irq_o); // R3

endmodule

bind irq_core_iface irq_core_iface_chk #(
   .ID_W(ID_W), .DATA_W(DATA_W), .NEST(NEST), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_addr (reg_wr_addr),
   .reg_wr_data (reg_wr_data),
   .reg_rd_en   (reg_rd_en),
   .reg_rd_addr (reg_rd_addr),
   .reg_rd_data (reg_rd_data),
   .act_valid   (act_valid),
   .act_id      (act_id),
   .done_valid  (done_valid),
   .done_id     (done_id),
   .irq_o       (irq_o)
);

// File: tb/test_irq_core_iface.sv
module test_irq_core_iface;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr_en;
   logic [1:0]  reg_wr_addr;
   logic [31:0] reg_wr_data;
   logic        reg_rd_en;
   logic [1:0]  reg_rd_addr;
   logic [31:0] reg_rd_data;
   logic        cand_valid;
   logic [9:0]  cand_id;
   logic [7:0]  cand_prio;
   logic        act_valid;
   logic [9:0]  act_id;
   logic        done_valid;
   logic [9:0]  done_id;
   logic        irq_o;

   always #2 clk = ~clk;

   irq_core_iface i_irq_core_iface (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
      .act_valid(act_valid), .act_id(act_id),
      .done_valid(done_valid), .done_id(done_id),
      .irq_o(irq_o)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // Reference model
   bit m_en = 1'b0;
   int m_mask = 0;
   int q_id[$];
   int q_pr[$];

   function automatic int run_pr();
      if (q_pr.size() > 0) return q_pr[$];
      return 255;
   endfunction

   task automatic check(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cyc(string tag, bit wr, int wa, int wd, bit rd, int ra,
                      bit cv, int cid, int cpr);
      bit e, ex_act, ex_done;
      longint ex_rd;
      reg_wr_en   = wr;
      reg_wr_addr = 2'(wa);
      reg_wr_data = 32'(wd);
      reg_rd_en   = rd;
      reg_rd_addr = 2'(ra);
      cand_valid  = cv;
      cand_id     = 10'(cid);
      cand_prio   = 8'(cpr);
      #1;
      e = m_en && cv && (cid < 1020) && (cpr < m_mask) && (cpr < run_pr())
          && (q_id.size() < 4);
      check(tag, "irq", longint'(irq_o), longint'(e));
      if (rd) begin
         case (ra)
            0: ex_rd = longint'(m_en);
            1: ex_rd = m_mask;
            2: ex_rd = e ? cid : 1023;
            default: ex_rd = run_pr();
         endcase
         check(tag, "rdata", longint'(reg_rd_data), ex_rd);
      end
      ex_act = rd && (ra == 2) && e;
      check(tag, "act_valid", longint'(act_valid), longint'(ex_act));
      if (ex_act) check(tag, "act_id", longint'(act_id), cid);
      ex_done = wr && (wa == 3) && (q_id.size() > 0) && ((wd & 1023) == q_id[$]);
      check(tag, "done_valid", longint'(done_valid), longint'(ex_done));
      if (ex_done) check(tag, "done_id", longint'(done_id), q_id[$]);
      // state update for the coming edge: completion first, then claim (R11)
      if (wr && wa == 0) m_en = wd[0];
      if (wr && wa == 1) m_mask = wd & 255;
      if (ex_done) begin
         void'(q_id.pop_back());
         void'(q_pr.pop_back());
      end
      if (ex_act) begin
         q_id.push_back(cid);
         q_pr.push_back(cpr);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog R1: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      reg_wr_en = 0; reg_wr_addr = 0; reg_wr_data = 0;
      reg_rd_en = 0; reg_rd_addr = 0;
      cand_valid = 0; cand_id = 0; cand_prio = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cyc("R1", 0, 0, 0, 1, 0, 0, 0, 0);
      cyc("R1", 0, 0, 0, 1, 1, 0, 0, 0);
      cyc("R1", 0, 0, 0, 1, 3, 0, 0, 0);
      // R3 disabled: no line, spurious ack
      cyc("R3", 0, 0, 0, 1, 2, 1, 40, 'h10);
      // R6 threshold strictness
      cyc("R6", 1, 1, 'hF0, 0, 0, 1, 40, 'h10);
      cyc("R3", 1, 0, 1, 0, 0, 1, 40, 'h10);
      cyc("R6", 0, 0, 0, 0, 0, 1, 40, 'hF0);
      cyc("R6", 0, 0, 0, 0, 0, 1, 40, 'hEF);
      // R4 claim
      cyc("R4", 0, 0, 0, 1, 2, 1, 40, 'h80);
      cyc("R4", 0, 0, 0, 1, 3, 0, 0, 0);
      // R5 not eligible (equal to running priority)
      cyc("R5", 0, 0, 0, 1, 2, 1, 41, 'h80);
      cyc("R5", 0, 0, 0, 1, 3, 1, 41, 'h80);
      // R9 nest to the limit
      cyc("R9", 0, 0, 0, 1, 2, 1, 50, 'h60);
      cyc("R9", 0, 0, 0, 1, 2, 1, 51, 'h40);
      cyc("R9", 0, 0, 0, 1, 2, 1, 52, 'h20);
      cyc("R9", 0, 0, 0, 1, 2, 1, 53, 'h10);
      // R8 mismatched completion
      cyc("R8", 1, 3, 51, 1, 3, 0, 0, 0);
      cyc("R8", 0, 0, 0, 1, 3, 0, 0, 0);
      // R7 matching completion
      cyc("R7", 1, 3, 52, 0, 0, 0, 0, 0);
      cyc("R7", 0, 0, 0, 1, 3, 0, 0, 0);
      // R11 claim and completion in one cycle
      cyc("R11", 1, 3, 51, 1, 2, 1, 60, 'h30);
      cyc("R11", 0, 0, 0, 1, 3, 0, 0, 0);
      cyc("R11", 0, 0, 0, 1, 2, 1, 61, 'h10);
      cyc("R11", 1, 3, 61, 1, 2, 1, 62, 'h05);
      cyc("R11", 0, 0, 0, 1, 3, 0, 0, 0);
      // R10 reserved IDs
      cyc("R10", 0, 0, 0, 1, 2, 1, 1021, 'h01);
      cyc("R10", 0, 0, 0, 1, 2, 1, 1020, 'h01);
      cyc("R10", 0, 0, 0, 1, 2, 1, 1023, 'h01);
      // R7 unwind to idle
      cyc("R7", 1, 3, 60, 1, 3, 0, 0, 0);
      cyc("R7", 1, 3, 50, 1, 3, 0, 0, 0);
      cyc("R7", 1, 3, 40, 1, 3, 0, 0, 0);
      cyc("R7", 0, 0, 0, 1, 3, 0, 0, 0);
      // R8 completion with nothing active
      cyc("R8", 1, 3, 40, 1, 3, 0, 0, 0);
      cyc("R8", 0, 0, 0, 1, 3, 0, 0, 0);
      // R3 disable while eligible
      cyc("R3", 0, 0, 0, 0, 0, 1, 70, 'h20);
      cyc("R3", 1, 0, 0, 0, 0, 1, 70, 'h20);
      cyc("R3", 0, 0, 0, 1, 2, 1, 70, 'h20);
      cyc("R2", 1, 0, 1, 0, 0, 1, 70, 'h20);
      cyc("R2", 1, 1, 'hC0, 0, 0, 1, 70, 'h20);

      // R2 / R11 mixed random traffic
      for (int k = 0; k < 3000; k++) begin
         bit wr = ($urandom_range(0, 2) == 0);
         bit rd = ($urandom_range(0, 1) == 0);
         int wa = $urandom_range(0, 3);
         int ra = $urandom_range(0, 3);
         int wd;
         int cid;
         if (wa == 0)      wd = ($urandom_range(0, 9) != 0) ? 1 : 0;
         else if (wa == 1) wd = $urandom_range('h40, 'hFF);
         else if (q_id.size() > 0 && $urandom_range(0, 2) != 0) wd = q_id[$];
         else              wd = $urandom_range(0, 1023);
         if (rd && $urandom_range(0, 1) == 0) ra = 2;
         if (wr && wa >= 2 && $urandom_range(0, 1) == 0) wa = 3;
         cid = ($urandom_range(0, 9) == 0) ? 1020 + $urandom_range(0, 3)
                                           : $urandom_range(0, 1019);
         cyc("R2", wr, wa, wd, rd, ra, ($urandom_range(0, 4) != 0), cid,
             $urandom_range(0, 255));
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule